// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers interrupt requests from eight external pins. Each pin passes through a two-flop synchronizer. A rising edge on the synchronized signal sets a sticky flag for that channel. The flag is set whether or not the channel is enabled, so software can poll sources that it has chosen not to forward.

An enable register decides which flagged channels raise a request toward the interrupt controller. The block drives one request line per channel and one combined line that is the OR of all eight.

Software uses a small synchronous byte bus. The enable register sits at byte address 0x28. The flag register sits at 0x29, the upper byte of the 16-bit word at 0x28. A flag is cleared by writing zero to its bit, and writing one to a bit leaves it alone. A read that is marked as part of a read-modify-write returns all ones from the flag register. The write-back of such a sequence therefore clears only the bits that software deliberately zeroed, and never a flag that arrived in between.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, and `chan_irq` and `irq` are all zero.
- R2: A low-to-high transition on `ext_pin[i]` sets flag bit i. The flag is visible from the third rising clock edge after the pin rises. A flag never becomes set without such an event.
- R3: A flag latches even when its enable bit is 0, and `chan_irq[i]` stays 0 while enable bit i is 0.
- R4: `chan_irq[i]` is 1 exactly when flag bit i and enable bit i are both 1. `irq` is the OR of all `chan_irq` bits.
- R5: A bus write to address 0x29 clears each flag whose data bit is 0. Flags whose data bit is 1 keep their value.
- R6: A read of 0x29 with `bus_rmw`=1 returns 0xFF. A read of 0x29 with `bus_rmw`=0 returns the flag bits, with bit i as channel i.
- R7: If a pin event and a zero-write to the same flag bit fall in the same cycle, the flag ends up set.
- R8: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented. Any address other than 0x28 or 0x29 reads as 0x00, and writes to it change nothing.
- R9: A write to 0x28 stores `bus_wdata` in the enable register, bit i enabling channel i. The stored value reads back at 0x28.
- R10: A pin held high sets its flag only once. After the flag is cleared it stays clear until the pin falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 8 | Asynchronous external request pins |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| bus_rdata | output | 8 | Read data, valid one cycle after the address |
| chan_irq | output | 8 | Per-channel request (flag AND enable) |
| irq | output | 1 | Combined request to the interrupt controller |

## Verification
Two functions can fall in the same cycle: a synchronized pin edge setting a flag, and a bus write that zeroes the same flag. The bench raises a pin on a falling edge. It then counts two rising edges, so that the edge-detect output is high in the coming cycle, and presents a flag write with that bit zero in exactly that cycle. The same write also zeroes a second, already pending bit. The readback must show the colliding bit set and the other bit cleared, which proves that the write took effect and that the set still won.

// File: rtl/xint_pkg.sv
package xint_pkg;
    parameter int unsigned NUM_CH      = 8;
    parameter int unsigned ADDR_W      = 16;
    parameter int unsigned SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(16'h0028);
    localparam logic [ADDR_W-1:0] FLAG_ADDR   = ENABLE_ADDR + ADDR_W'(1);

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_FLAG   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic    en_wr;
        logic    flag_wr;
        ch_vec_t data;
    } reg_write_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a == ENABLE_ADDR)    return SEL_ENABLE;
        else if (a == FLAG_ADDR) return SEL_FLAG;
        else                     return SEL_NONE;
    endfunction

    // Bits that a flag write zeroes: a 0 in the data clears, a 1 keeps.
    function automatic ch_vec_t clear_mask(reg_write_t w);
        return w.flag_wr ? ~w.data : '0;
    endfunction
endpackage

// File: rtl/xint_pin_sync.sv
module xint_pin_sync
    import xint_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t pin_async,
    output ch_vec_t rise_pulse
);
    // Stages 0..SYNC_STAGES-1 synchronize; the last stage holds the previous value.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [SYNC_STAGES:0] shift_q;

        always_ff @(posedge clk) begin
            if (rst) shift_q <= '0;
            else     shift_q <= {shift_q[SYNC_STAGES-1:0], pin_async[ch]};
        end

        assign rise_pulse[ch] = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    end

    // R10: an edge lasts a single cycle, so a held level cannot set again
    p_edge_single_r10: assert property (@(posedge clk) disable iff (rst)
        (|rise_pulse) |=> ((rise_pulse & $past(rise_pulse)) == '0));
endmodule

// File: rtl/xint_flag_bank.sv
module xint_flag_bank
    import xint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ch_vec_t    rise_pulse,
    input  reg_write_t wr_req,
    output ch_vec_t    flags_q
);
    ch_vec_t flags_d;

    // A set has priority over a clear in the same cycle.
    always_comb begin
        flags_d = (flags_q & ~clear_mask(wr_req)) | rise_pulse;
    end

    // The reset value is left open; zero is chosen here.
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // R7: every detected edge is recorded, whatever the bus does
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|rise_pulse) |=> ((flags_q & $past(rise_pulse)) == $past(rise_pulse)));

    // R2: a flag only rises after an edge on its pin
    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(rise_pulse)) == '0));
endmodule

// File: rtl/xint_regs.sv
module xint_regs
    import xint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  ch_vec_t           bus_wdata,
    input  logic              bus_rmw,
    input  ch_vec_t           flags_q,
    output reg_write_t        wr_req,
    output ch_vec_t           enable_q,
    output ch_vec_t           rdata_q
);
    reg_sel_e sel;
    ch_vec_t  rd_mux;

    always_comb begin
        sel            = decode_addr(bus_addr);
        wr_req.en_wr   = bus_wr && (sel == SEL_ENABLE);
        wr_req.flag_wr = bus_wr && (sel == SEL_FLAG);
        wr_req.data    = bus_wdata;
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rd_mux = enable_q;
            SEL_FLAG:   rd_mux = bus_rmw ? '1 : flags_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (wr_req.en_wr) enable_q <= wr_req.data;
            rdata_q <= rd_mux;
        end
    end

    // R9: an enable write lands in the register on the next edge
    p_enable_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ENABLE_ADDR) |=> (enable_q == $past(bus_wdata)));

    // R6: a read-modify-write read of the flags returns all ones
    p_rmw_read_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rmw && bus_addr == FLAG_ADDR) |=> (rdata_q == '1));

    // R8: foreign addresses read as zero and leave the enables alone
    p_foreign_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ENABLE_ADDR && bus_addr != FLAG_ADDR)
        |=> (rdata_q == '0 && $stable(enable_q)));
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ext_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NUM_CH-1:0] bus_wdata,
    input  logic              bus_rmw,
    output logic [NUM_CH-1:0] bus_rdata,
    output logic [NUM_CH-1:0] chan_irq,
    output logic              irq
);
    ch_vec_t    rise_pulse;
    ch_vec_t    flags_q;
    ch_vec_t    enable_q;
    reg_write_t wr_req;

    xint_pin_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_async  (ext_pin),
        .rise_pulse (rise_pulse)
    );

    xint_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .rise_pulse (rise_pulse),
        .wr_req     (wr_req),
        .flags_q    (flags_q)
    );

    xint_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rmw   (bus_rmw),
        .flags_q   (flags_q),
        .wr_req    (wr_req),
        .enable_q  (enable_q),
        .rdata_q   (bus_rdata)
    );

    assign chan_irq = flags_q & enable_q;
    assign irq      = |chan_irq;

    // R1: the enables come out of reset cleared
    p_reset_enable_r1: assert property (@(posedge clk)
        $past(rst) |-> (enable_q == '0));

    // R3: a flag held while its channel is disabled raises no request
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(enable_q) == '0 && $stable(enable_q)) |-> (irq == 1'b0));
endmodule

// File: tb/xint_ctrl_test.sv
module xint_ctrl_test;
    localparam logic [15:0] A_EN   = 16'h0028;
    localparam logic [15:0] A_FLAG = 16'h0029;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ext_pin = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rmw = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  chan_irq;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    xint_ctrl uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rmw(bus_rmw),
        .bus_rdata(bus_rdata), .chan_irq(chan_irq), .irq(irq)
    );

    // Entry: {enable, pins pulsed, flag write data, expected flags}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'hA5, 8'hFF, 8'hA5},
        {8'h0F, 8'h00, 8'hFF, 8'hA5},
        {8'hF0, 8'h00, 8'h7F, 8'h25},
        {8'h00, 8'h18, 8'hFB, 8'h39},
        {8'hFF, 8'h42, 8'h00, 8'h00},
        {8'h81, 8'h81, 8'hFF, 8'h81}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic rmw, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rmw = rmw;
        @(negedge clk);
        d = bus_rdata;
        bus_rmw = 1'b0;
    endtask

    task automatic pulse_pins(input logic [7:0] m);
        @(negedge clk);
        ext_pin = ext_pin | m;
        repeat (4) @(negedge clk);
        ext_pin = ext_pin & ~m;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_read(A_EN, 1'b0, rd);
        chk("R1 enable after reset", rd, 8'h00);
        chk("R1 chan_irq after reset", chan_irq, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);

        bus_write(A_FLAG, 8'h00);   // flag reset value is not relied on

        // Table walk: R3, R4, R5, R9
        for (int i = 0; i < NV; i++) begin
            logic [7:0] en, pm, wd, ef;
            {en, pm, wd, ef} = VEC[i];
            bus_write(A_EN, en);
            if (pm != 8'h00) pulse_pins(pm);
            bus_write(A_FLAG, wd);
            bus_read(A_FLAG, 1'b0, rd);
            chk("R5 R3 flag readback", rd, ef);
            chk("R4 chan_irq", chan_irq, ef & en);
            chk("R4 irq", {7'b0, irq}, {7'b0, |(ef & en)});
        end
        bus_read(A_EN, 1'b0, rd);
        chk("R9 enable readback", rd, 8'h81);

        // R2: flag latency, visible from the third rising edge after the pin rises
        bus_write(A_FLAG, 8'h00);
        bus_write(A_EN, 8'h02);
        @(negedge clk);
        ext_pin[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet set after two edges", chan_irq, 8'h00);
        @(negedge clk);
        chk("R2 set after three edges", chan_irq, 8'h02);
        ext_pin[1] = 1'b0;

        // R10: held level sets only once
        bus_write(A_FLAG, 8'h00);
        @(negedge clk);
        ext_pin[3] = 1'b1;
        repeat (5) @(negedge clk);
        bus_write(A_FLAG, 8'h00);
        repeat (5) @(negedge clk);
        bus_read(A_FLAG, 1'b0, rd);
        chk("R10 held pin does not re-set", rd, 8'h00);
        ext_pin[3] = 1'b0;
        repeat (3) @(negedge clk);
        pulse_pins(8'h08);
        bus_read(A_FLAG, 1'b0, rd);
        chk("R10 new edge sets again", rd, 8'h08);

        // R6: read-modify-write keeps other pending flags
        bus_write(A_FLAG, 8'h00);
        pulse_pins(8'h0C);
        bus_read(A_FLAG, 1'b1, rd);
        chk("R6 rmw read returns ones", rd, 8'hFF);
        bus_write(A_FLAG, rd & ~8'h04);
        bus_read(A_FLAG, 1'b0, rd);
        chk("R6 rmw clears only bit 2", rd, 8'h08);

        // R8: foreign address
        bus_write(A_EN, 8'h3C);
        bus_write(16'h002A, 8'hFF);
        bus_write(16'h0128, 8'h00);
        bus_read(16'h002A, 1'b0, rd);
        chk("R8 foreign address reads zero", rd, 8'h00);
        bus_read(A_EN, 1'b0, rd);
        chk("R8 foreign writes ignored", rd, 8'h3C);

        // R7: same-cycle set and clear; bit 3 is pending and also zeroed
        @(negedge clk);
        ext_pin[5] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = A_FLAG; bus_wdata = 8'hD7; bus_wr = 1'b1;   // zeroes bits 5 and 3
        @(negedge clk);
        bus_wr = 1'b0;
        ext_pin[5] = 1'b0;
        bus_read(A_FLAG, 1'b0, rd);
        chk("R7 set wins over clear", rd, 8'h20);
        chk("R7 chan_irq after collision", chan_irq, 8'h20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule